// File: doc/BRIEF.md
# Multi-Bank DRAM Command Timing Checker

This block watches the command stream that a memory controller sends to a banked DRAM and judges every command against the row-timing rules of the addressed bank. One command arrives per clock: open a row (activate), read a column, close the row (precharge), or idle. The block keeps the open/closed state and two age counters for each bank. When a command breaks a rule, it raises a one-cycle error pulse that carries a rule code and the bank number. For every accepted read, it predicts the cycle in which the read data will appear.

The monitor is passive. It never stalls the stream and has no ready signal, so the producer cannot be held back. The idle code stands for "no command". A command that the block flags is treated as if it never happened: bank state and the read schedule are left as they were. The bank count and every timing value are parameters in clock cycles.

Top module: `dram_cmd_monitor`

## Requirements
- R1: After reset every bank is closed, `err_valid` and `rd_due` are low, and every timing rule already counts as met, so the first activate to any bank is accepted.
- R2: An accepted activate opens its bank and an accepted precharge closes it. `bank_open[b]` shows the state of bank b from the cycle after the command. Banks are tracked independently and may be open at the same time.
- R3: A read to an open bank issued fewer than T_RCD cycles after that bank's accepted activate is flagged with code 1.
- R4: A precharge to an open bank issued fewer than T_RAS cycles after its accepted activate is flagged with code 2.
- R5: An activate to a closed bank issued fewer than T_RP cycles after its accepted precharge is flagged with code 3.
- R6: An activate that meets R5 but comes fewer than T_RC cycles after the bank's previous accepted activate is flagged with code 4.
- R7: State errors take priority over timing errors. A read to a closed bank gives code 5, a precharge to a closed bank gives code 6, and an activate to an open bank gives code 7.
- R8: For a flagged command, `err_valid` is high for exactly the next cycle, with `err_code` and `err_bank` set. A flagged command changes no bank state and schedules no read data.
- R9: For an accepted read issued in cycle t, `rd_due` is high in cycle t+T_CL with `rd_due_bank` set to that bank. Reads issued back to back produce back-to-back pulses.
- R10: Command encoding on `cmd_op` is 0 idle, 1 activate, 2 read, 3 precharge. An idle cycle never raises an error and never changes state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command code (R10) |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| err_valid | output | 1 | One-cycle rule-violation pulse |
| err_code | output | 3 | Broken rule, codes 1 to 7 |
| err_bank | output | BANK_W | Bank of the flagged command |
| rd_due | output | 1 | Read data expected this cycle |
| rd_due_bank | output | BANK_W | Bank whose read data is due |
| bank_open | output | NUM_BANKS | Per-bank open flag |

## Verification
An error pulse and a read-data-due pulse can fall in the same cycle. This happens when a faulty command arrives T_CL-1 cycles after an accepted read, usually on a different bank. The bench builds this case on purpose: it interleaves back-to-back reads across banks with an activate to an already-open bank. It then checks both pulses, with their codes and banks, against a behavioural model in that shared cycle. The model also runs a long pseudo-random command stream, so that collisions between the two kinds of pulse happen again under varied timing.

// File: rtl/dram_mon_pkg.sv
package dram_mon_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_ACT  = 2'd1,
    OP_RD   = 2'd2,
    OP_PRE  = 2'd3
  } mon_op_e;

  typedef enum logic [2:0] {
    V_NONE     = 3'd0,
    V_RCD      = 3'd1,
    V_RAS      = 3'd2,
    V_RP       = 3'd3,
    V_RC       = 3'd4,
    V_RD_IDLE  = 3'd5,
    V_PRE_IDLE = 3'd6,
    V_ACT_BUSY = 3'd7
  } viol_e;
endpackage

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int T_RCD = 3,
  parameter int T_RAS = 5,
  parameter int T_RP  = 3,
  parameter int T_RC  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic pre_go,
  output logic is_open,
  output logic rcd_met,
  output logic ras_met,
  output logic rp_met,
  output logic rc_met
);
  localparam int LIM_A   = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int ACT_LIM = (LIM_A > T_RCD) ? LIM_A : T_RCD;
  localparam int ACT_W   = $clog2(ACT_LIM + 1);
  localparam int PRE_W   = $clog2(T_RP + 1);

  logic             open_q;
  logic [ACT_W-1:0] act_age_q;  // cycles since last accepted activate
  logic [PRE_W-1:0] pre_age_q;  // cycles since last accepted precharge

  // Counters start saturated so every rule is met out of reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      act_age_q <= ACT_W'(ACT_LIM);
      pre_age_q <= PRE_W'(T_RP);
    end else begin
      if (act_go) begin
        open_q    <= 1'b1;
        act_age_q <= ACT_W'(1);
      end else if (act_age_q != ACT_W'(ACT_LIM)) begin
        act_age_q <= act_age_q + ACT_W'(1);
      end
      if (pre_go) begin
        open_q    <= 1'b0;
        pre_age_q <= PRE_W'(1);
      end else if (pre_age_q != PRE_W'(T_RP)) begin
        pre_age_q <= pre_age_q + PRE_W'(1);
      end
    end
  end

  assign is_open = open_q;
  assign rcd_met = act_age_q >= ACT_W'(T_RCD);
  assign ras_met = act_age_q >= ACT_W'(T_RAS);
  assign rc_met  = act_age_q >= ACT_W'(T_RC);
  assign rp_met  = pre_age_q >= PRE_W'(T_RP);
endmodule

// File: rtl/dram_cmd_judge.sv
module dram_cmd_judge
  import dram_mon_pkg::*;
(
  input  mon_op_e op,
  input  logic    is_open,
  input  logic    rcd_met,
  input  logic    ras_met,
  input  logic    rp_met,
  input  logic    rc_met,
  output viol_e   viol
);
  // State errors first, then the timing rules in a fixed order.
  always_comb begin
    viol = V_NONE;
    unique case (op)
      OP_ACT: begin
        if (is_open)      viol = V_ACT_BUSY;
        else if (!rp_met) viol = V_RP;
        else if (!rc_met) viol = V_RC;
      end
      OP_RD: begin
        if (!is_open)      viol = V_RD_IDLE;
        else if (!rcd_met) viol = V_RCD;
      end
      OP_PRE: begin
        if (!is_open)      viol = V_PRE_IDLE;
        else if (!ras_met) viol = V_RAS;
      end
      default: viol = V_NONE;
    endcase
  end
endmodule

// File: rtl/dram_rd_pipe.sv
module dram_rd_pipe #(
  parameter int DEPTH  = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic [BANK_W-1:0] in_bank,
  output logic              out_fire,
  output logic [BANK_W-1:0] out_bank
);
  logic [DEPTH-1:0]  vld_q;
  logic [BANK_W-1:0] bank_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) bank_q[i] <= '0;
    end else begin
      vld_q[0]  <= in_fire;
      bank_q[0] <= in_bank;
      for (int i = 1; i < DEPTH; i++) begin
        vld_q[i]  <= vld_q[i-1];
        bank_q[i] <= bank_q[i-1];
      end
    end
  end

  assign out_fire = vld_q[DEPTH-1];
  assign out_bank = bank_q[DEPTH-1];
endmodule

// File: rtl/dram_cmd_monitor.sv
module dram_cmd_monitor
  import dram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_CL      = 4,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  output logic                 err_valid,
  output logic [2:0]           err_code,
  output logic [BANK_W-1:0]    err_bank,
  output logic                 rd_due,
  output logic [BANK_W-1:0]    rd_due_bank,
  output logic [NUM_BANKS-1:0] bank_open
);
  mon_op_e op;
  viol_e   viol;
  logic    accept;

  logic [NUM_BANKS-1:0] open_v, rcd_v, ras_v, rp_v, rc_v;

  assign op     = mon_op_e'(cmd_op);
  assign accept = (viol == V_NONE);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BANK_W'(g)) && accept;
    dram_bank_tracker #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)
    ) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_go  (hit && (op == OP_ACT)),
      .pre_go  (hit && (op == OP_PRE)),
      .is_open (open_v[g]),
      .rcd_met (rcd_v[g]),
      .ras_met (ras_v[g]),
      .rp_met  (rp_v[g]),
      .rc_met  (rc_v[g])
    );
  end

  dram_cmd_judge u_judge (
    .op      (op),
    .is_open (open_v[cmd_bank]),
    .rcd_met (rcd_v[cmd_bank]),
    .ras_met (ras_v[cmd_bank]),
    .rp_met  (rp_v[cmd_bank]),
    .rc_met  (rc_v[cmd_bank]),
    .viol    (viol)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_code  <= 3'd0;
      err_bank  <= '0;
    end else begin
      err_valid <= !accept;
      err_code  <= viol;
      err_bank  <= cmd_bank;
    end
  end

  dram_rd_pipe #(.DEPTH(T_CL), .BANK_W(BANK_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (accept && (op == OP_RD)),
    .in_bank  (cmd_bank),
    .out_fire (rd_due),
    .out_bank (rd_due_bank)
  );

  assign bank_open = open_v;
endmodule

// File: rtl/dram_cmd_monitor_chk.sv
module dram_cmd_monitor_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           cmd_op,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 err_valid,
  input logic [2:0]           err_code,
  input logic [BANK_W-1:0]    err_bank,
  input logic [NUM_BANKS-1:0] bank_open
);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd0) |=> !err_valid);

  assert_act_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd1 && bank_open[cmd_bank])
      |=> (err_valid && err_code == 3'd7 && err_bank == $past(cmd_bank)));

  assert_rd_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd2 && !bank_open[cmd_bank])
      |=> (err_valid && err_code == 3'd5));

  assert_pre_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd3 && !bank_open[cmd_bank])
      |=> (err_valid && err_code == 3'd6));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
    assert_open_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_open[i]) |-> $past(cmd_op == 2'd1 && cmd_bank == BANK_W'(i)));
    assert_close_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_open[i]) |-> $past(cmd_op == 2'd3 && cmd_bank == BANK_W'(i)));
  end
endmodule

bind dram_cmd_monitor dram_cmd_monitor_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_op    (cmd_op),
  .cmd_bank  (cmd_bank),
  .err_valid (err_valid),
  .err_code  (err_code),
  .err_bank  (err_bank),
  .bank_open (bank_open)
);

// File: tb/dram_cmd_monitor_tb.sv
module dram_cmd_monitor_tb;
  localparam int NB = 4, RCD = 3, CL = 4, RAS = 5, RP = 3, RC = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       err_valid, rd_due;
  logic [2:0] err_code;
  logic [1:0] err_bank, rd_due_bank;
  logic [3:0] bank_open;

  always #4 clk = ~clk;

  dram_cmd_monitor #(.NUM_BANKS(NB), .T_RCD(RCD), .T_CL(CL), .T_RAS(RAS),
                     .T_RP(RP), .T_RC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .err_valid(err_valid), .err_code(err_code), .err_bank(err_bank),
    .rd_due(rd_due), .rd_due_bank(rd_due_bank), .bank_open(bank_open));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int code, int op);
    if (op == 0) return "R10";
    case (code)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6, 7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Behavioural reference model
  int m_open[NB], m_act[NB], m_pre[NB];
  int due_q[$], dueb_q[$];
  int cyc = 0, last_op = 0;
  bit live = 0;
  int e_code = 0, e_bank = 0, e_dueb = 0, e_mask = 0;
  bit e_due = 0;

  initial for (int b = 0; b < NB; b++) begin
    m_open[b] = 0; m_act[b] = -1000; m_pre[b] = -1000;
  end

  always @(posedge clk) if (rst_n) begin
    int op, b, code;
    op = cmd_op; b = cmd_bank; code = 0;
    case (op)
      1: if (m_open[b] != 0) code = 7;
         else if (cyc - m_pre[b] < RP) code = 3;
         else if (cyc - m_act[b] < RC) code = 4;
      2: if (m_open[b] == 0) code = 5;
         else if (cyc - m_act[b] < RCD) code = 1;
      3: if (m_open[b] == 0) code = 6;
         else if (cyc - m_act[b] < RAS) code = 2;
      default: code = 0;
    endcase
    if (code == 0) begin
      if (op == 1) begin m_open[b] = 1; m_act[b] = cyc; end
      if (op == 3) begin m_open[b] = 0; m_pre[b] = cyc; end
      if (op == 2) begin due_q.push_back(cyc + CL); dueb_q.push_back(b); end
    end
    e_code = code; e_bank = b; last_op = op;
    cyc++;
    e_due = 0;
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      e_due = 1; e_dueb = dueb_q[0];
      void'(due_q.pop_front()); void'(dueb_q.pop_front());
    end
    e_mask = 0;
    for (int k = 0; k < NB; k++) if (m_open[k] != 0) e_mask |= (1 << k);
    live = 1;
  end

  always @(negedge clk) if (live && !done) begin
    string t;
    t = tag_of((e_code != 0) ? e_code : int'(err_code), last_op);
    chk(err_valid == (e_code != 0), t, "err_valid", err_valid, e_code != 0);
    if (e_code != 0) begin
      chk(err_code == e_code && err_bank == e_bank, t, "err_code*4+bank",
          err_code * 4 + err_bank, e_code * 4 + e_bank);
    end
    chk(rd_due == e_due, "R9", "rd_due", rd_due, e_due);
    if (e_due) chk(rd_due_bank == e_dueb, "R9", "rd_due_bank", rd_due_bank, e_dueb);
    chk(bank_open == e_mask, (e_code != 0) ? "R8" : "R2", "bank_open",
        bank_open, e_mask);
  end

  task automatic issue(int op, int b);
    cmd_op = op[1:0]; cmd_bank = b[1:0];
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_err++; n_chk++;
    $display("FAIL watchdog all-reqs actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seed;
    seed = 7;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(err_valid == 0, "R1", "err_valid in reset", err_valid, 0);
    chk(rd_due == 0, "R1", "rd_due in reset", rd_due, 0);
    chk(bank_open == 0, "R1", "bank_open in reset", bank_open, 0);
    rst_n = 1;
    // R1 first ACT accepted; R3 early read then legal read (R9)
    issue(1, 0); issue(2, 0); issue(0, 0); issue(2, 0);
    // R4 early precharge, then legal
    issue(3, 0); issue(3, 0);
    // R5 early activate; R7 closed-bank read/precharge; legal ACT; R7 busy ACT
    issue(1, 0); issue(2, 2); issue(3, 2); issue(1, 0); issue(1, 0);
    // R6: RP met but RC not, then RC met
    issue(1, 1); repeat (4) issue(0, 0); issue(3, 1); repeat (2) issue(0, 0);
    issue(1, 1); issue(1, 1);
    // Interleaved banks, back-to-back reads, error colliding with rd_due
    issue(1, 2); issue(1, 3); issue(0, 0); issue(0, 0);
    issue(2, 2); issue(2, 3); issue(2, 1); issue(2, 0);
    issue(1, 1); issue(1, 3); issue(2, 0); issue(1, 0);
    // R10 idle stretch
    repeat (6) issue(0, 0);
    // Pseudo-random stream
    for (int n = 0; n < 3000; n++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 16) & 16'h7fff;
      if (r % 3 == 0) issue(0, 0);
      else issue((r >> 2) % 4, (r >> 5) % 4);
    end
    repeat (CL + 4) issue(0, 0);
    finish_run();
  end
endmodule